// File: doc/BRIEF.md
# Earliest-Deadline Urgent Request Selector

This block is the first arbitration level in front of a shared bus for masters with hard real-time needs. Each such master raises a request line and, on the cycle the line rises, presents a relative deadline: the number of cycles within which its transaction must complete. The block keeps one countdown of remaining cycles per master. The countdown runs until the master signals completion or withdraws its request.

On each arbitration slot the block looks at every pending request. It compares the remaining time of each against a programmable warning threshold. The threshold stands for the worst-case time needed to serve the contending traffic. If one or more pending requests have fallen to or below the threshold, the block grants the one with the least remaining time, and the grant is marked urgent. If none has, the block grants nothing and the slot passes to a lower-level arbiter.

Separately, the block raises a per-master miss flag when a countdown is exhausted and the transaction has still not completed.

Top module: `edf_urgent_sel`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is released, `urg_grant_o`, `urg_valid_o` and `miss_o` are all zero.
- R2: A master's request is captured at the first clock edge where `req_i[m]` is high after having been low at the previous edge. At that edge the master's remaining time is loaded from `deadline_i[m*CNT_W +: CNT_W]`, the master becomes pending, and `miss_o[m]` is cleared.
- R3: If the loading edge is edge k with deadline D, and the request neither completes nor drops, then `miss_o[m]` is low up to and including edge k+D and is high after edge k+D+1. It then stays high until the master's next captured request, even if the request line falls.
- R4: A `done_i[m]` pulse seen at an edge while master m is pending ends the pending state. The master is not granted afterwards and no miss is raised for that request.
- R5: At a slot, a pending master takes part only when its remaining time is less than or equal to `warn_i`. The remaining time at an edge k+j (j at least 1) is D-(j-1), so a threshold equal to the remaining time qualifies and a threshold one lower does not.
- R6: Among the qualifying masters the one with the smallest remaining time is granted, whatever its index. Equal remaining times go to the lowest master index.
- R7: When no pending master qualifies, the slot result is `urg_grant_o` = 0 and `urg_valid_o` = 0, handing the slot to the lower level.
- R8: The result for a slot appears on the outputs right after the clock edge that samples `slot_i` high and lasts one cycle. After an edge that samples `slot_i` low, the grant is zero.
- R9: `urg_grant_o` has at most one bit set (bit m selects master m), and `urg_valid_o` is high exactly when a bit is set.
- R10: A request line that falls while pending (sampled low at an edge) ends the pending state without raising a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Request level per real-time master |
| deadline_i | input | N_MASTERS*CNT_W | Relative deadline per master, sampled when its request rises |
| warn_i | input | CNT_W | Warning threshold in cycles |
| done_i | input | N_MASTERS | Transaction-complete pulse per master |
| slot_i | input | 1 | Arbitration slot strobe |
| urg_grant_o | output | N_MASTERS | One-hot urgent grant, registered |
| urg_valid_o | output | 1 | An urgent grant was made for the last slot |
| miss_o | output | N_MASTERS | Sticky deadline-miss flag per master |

## Verification
A slot result is due one clock after the edge that samples the strobe. The scoreboard therefore compares it 1 ns after that rising edge, while the strobe driven at the preceding falling edge is still high. A miss flag is due D+1 edges after the loading edge. The bench counts falling edges from the cycle in which it raised the request and reads the flag at the falling edge just before and just after that point. Remaining times used by the slot checks are derived from the same edge count, so each expected grant follows from the R5 formula rather than from the design.

// File: rtl/edf_pkg.sv
package edf_pkg;
  localparam int unsigned DEF_MASTERS = 4;
  localparam int unsigned DEF_CNT_W   = 12;
endpackage

// File: rtl/edf_lane.sv
// One master's deadline tracker: captures a request on its rising level,
// counts down the remaining cycles and flags an expired request.
module edf_lane #(
  parameter int unsigned CNT_W = edf_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CNT_W-1:0] deadline,
  input  logic             done,
  output logic             pend_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             miss_o
);
  logic             req_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             miss_q;
  logic             new_req;

  assign new_req = req && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      req_q <= req;
      if (new_req) begin
        cnt_q  <= deadline;
        pend_q <= 1'b1;
        miss_q <= 1'b0;
      end else if (pend_q) begin
        if (done || !req) begin
          pend_q <= 1'b0;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          miss_q <= 1'b1;
        end
      end
    end
  end

  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;
  assign miss_o = miss_q;
endmodule

// File: rtl/edf_min_pick.sv
// Finds the qualifying master with the smallest remaining time; a later
// index replaces the running best only when strictly smaller, so ties keep
// the lowest index.
module edf_min_pick #(
  parameter int unsigned N_MASTERS = edf_pkg::DEF_MASTERS,
  parameter int unsigned CNT_W     = edf_pkg::DEF_CNT_W
) (
  input  logic [N_MASTERS-1:0]       elig,
  input  logic [N_MASTERS*CNT_W-1:0] cnt_flat,
  output logic                       found_o,
  output logic [N_MASTERS-1:0]       onehot_o
);
  localparam int unsigned IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS:0] c_found;
  logic [CNT_W-1:0]   c_val [N_MASTERS+1];
  logic [IDX_W-1:0]   c_idx [N_MASTERS+1];

  assign c_found[0] = 1'b0;
  assign c_val[0]   = '0;
  assign c_idx[0]   = '0;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_stage
    logic [CNT_W-1:0] val;
    logic             take;
    assign val  = cnt_flat[i*CNT_W +: CNT_W];
    assign take = elig[i] && (!c_found[i] || (val < c_val[i]));
    assign c_found[i+1] = c_found[i] | elig[i];
    assign c_val[i+1]   = take ? val : c_val[i];
    assign c_idx[i+1]   = take ? IDX_W'(i) : c_idx[i];
  end

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_dec
    assign onehot_o[i] = c_found[N_MASTERS] && (c_idx[N_MASTERS] == IDX_W'(i));
  end

  assign found_o = c_found[N_MASTERS];
endmodule

// File: rtl/edf_urgent_sel.sv
module edf_urgent_sel #(
  parameter int unsigned N_MASTERS = edf_pkg::DEF_MASTERS,
  parameter int unsigned CNT_W     = edf_pkg::DEF_CNT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_MASTERS-1:0]       req_i,
  input  logic [N_MASTERS*CNT_W-1:0] deadline_i,
  input  logic [CNT_W-1:0]           warn_i,
  input  logic [N_MASTERS-1:0]       done_i,
  input  logic                       slot_i,
  output logic [N_MASTERS-1:0]       urg_grant_o,
  output logic                       urg_valid_o,
  output logic [N_MASTERS-1:0]       miss_o
);
  logic [N_MASTERS-1:0]       pend;
  logic [N_MASTERS-1:0]       elig;
  logic [N_MASTERS*CNT_W-1:0] cnt_flat;
  logic                       pick_found;
  logic [N_MASTERS-1:0]       pick_onehot;
  logic [N_MASTERS-1:0]       grant_q;
  logic                       valid_q;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_lane
    edf_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .req      (req_i[i]),
      .deadline (deadline_i[i*CNT_W +: CNT_W]),
      .done     (done_i[i]),
      .pend_o   (pend[i]),
      .cnt_o    (cnt_flat[i*CNT_W +: CNT_W]),
      .miss_o   (miss_o[i])
    );
    assign elig[i] = pend[i] && (cnt_flat[i*CNT_W +: CNT_W] <= warn_i);
  end

  edf_min_pick #(.N_MASTERS(N_MASTERS), .CNT_W(CNT_W)) u_pick (
    .elig     (elig),
    .cnt_flat (cnt_flat),
    .found_o  (pick_found),
    .onehot_o (pick_onehot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      valid_q <= 1'b0;
    end else if (slot_i) begin
      grant_q <= pick_onehot;
      valid_q <= pick_found;
    end else begin
      grant_q <= '0;
      valid_q <= 1'b0;
    end
  end

  assign urg_grant_o = grant_q;
  assign urg_valid_o = valid_q;
endmodule

// File: rtl/edf_urgent_sel_chk.sv
module edf_urgent_sel_chk #(
  parameter int unsigned N_MASTERS = edf_pkg::DEF_MASTERS
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MASTERS-1:0] req_i,
  input logic [N_MASTERS-1:0] done_i,
  input logic                 slot_i,
  input logic [N_MASTERS-1:0] urg_grant_o,
  input logic                 urg_valid_o,
  input logic [N_MASTERS-1:0] miss_o
);
  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(urg_grant_o));

  p_valid_match_r9: assert property (@(posedge clk) disable iff (rst)
    urg_valid_o == (|urg_grant_o));

  p_grant_after_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (|urg_grant_o) |-> $past(slot_i));

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_m
    p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
      urg_grant_o[i] |-> $past(req_i[i]));

    p_rise_clears_miss_r2: assert property (@(posedge clk) disable iff (rst)
      (req_i[i] && !$past(req_i[i])) |=> !miss_o[i]);

    p_done_no_miss_r4: assert property (@(posedge clk) disable iff (rst)
      (done_i[i] && !miss_o[i]) |=> !miss_o[i]);
  end
endmodule

bind edf_urgent_sel edf_urgent_sel_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .done_i      (done_i),
  .slot_i      (slot_i),
  .urg_grant_o (urg_grant_o),
  .urg_valid_o (urg_valid_o),
  .miss_o      (miss_o)
);

// File: tb/edf_urgent_sel_test.sv
`timescale 1ns/1ps
module edf_urgent_sel_test;
  localparam int N = 4;
  localparam int W = 12;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   req_i = '0;
  logic [N*W-1:0] deadline_i = '0;
  logic [W-1:0]   warn_i = '0;
  logic [N-1:0]   done_i = '0;
  logic           slot_i = 1'b0;
  logic [N-1:0]   urg_grant_o;
  logic           urg_valid_o;
  logic [N-1:0]   miss_o;

  int compared = 0;
  int mismatched = 0;

  logic [N-1:0] exp_q [$];
  string        tag_q [$];

  always #2.5 clk = ~clk;

  edf_urgent_sel uut (
    .clk(clk), .rst(rst), .req_i(req_i), .deadline_i(deadline_i),
    .warn_i(warn_i), .done_i(done_i), .slot_i(slot_i),
    .urg_grant_o(urg_grant_o), .urg_valid_o(urg_valid_o), .miss_o(miss_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start(input int m, input int d);
    req_i[m] = 1'b1;
    deadline_i[m*W +: W] = W'(d);
  endtask

  // driver: strobe one slot and push the expected result
  task automatic arb(input logic [N-1:0] exp, input string tag);
    slot_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    slot_i = 1'b0;
  endtask

  task automatic idle();
    req_i = '0;
    done_i = '0;
    slot_i = 1'b0;
    tick(3);
  endtask

  // monitor: result is due right after the edge that sampled the strobe
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (slot_i && exp_q.size() > 0) begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " grant"}, 32'(urg_grant_o), 32'(e));
        chk({t, " valid"}, 32'(urg_valid_o), 32'(e != '0));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 grant in reset", 32'(urg_grant_o), 0);
    rst = 1'b0;
    tick(1);
    chk("R1 grant after reset", 32'(urg_grant_o), 0);
    chk("R1 valid after reset", 32'(urg_valid_o), 0);
    chk("R1 miss after reset", 32'(miss_o), 0);

    // Tie on equal remaining, then done removes winner (R6, R4, R7, R5)
    warn_i = 12'd5;
    start(1, 20); start(2, 4); start(3, 4);
    tick(1);
    arb(4'b0100, "R6 tie lowest index");
    done_i[2] = 1'b1; tick(1); done_i[2] = 1'b0;
    arb(4'b1000, "R4 done master skipped");
    done_i[3] = 1'b1; tick(1); done_i[3] = 1'b0;
    arb(4'b0000, "R7 none under warning");
    warn_i = 12'd4095;
    arb(4'b0010, "R5 threshold raised");
    idle();

    // Threshold boundary (R5)
    start(0, 10);
    tick(1);
    warn_i = 12'd10;
    arb(4'b0001, "R5 remaining equal warn");
    warn_i = 12'd8;
    arb(4'b0000, "R5 remaining above warn");
    arb(4'b0001, "R5 remaining reaches warn");
    idle();

    // Smaller remaining beats lower index (R6)
    warn_i = 12'd10;
    start(0, 3); start(1, 2);
    tick(1);
    arb(4'b0010, "R6 smallest remaining");
    idle();
    start(0, 5); start(1, 5); start(3, 5);
    tick(1);
    arb(4'b0001, "R6 three-way tie");
    idle();

    // Withdrawn request (R10)
    warn_i = 12'd4095;
    start(1, 50);
    tick(1);
    req_i[1] = 1'b0;
    tick(1);
    arb(4'b0000, "R10 dropped not granted");
    tick(60);
    chk("R10 no miss after drop", 32'(miss_o), 0);
    idle();

    // Deadline miss timing and stickiness (R3, R2, R4)
    start(0, 3);
    tick(1);
    tick(3);
    chk("R3 no miss at k+D", 32'(miss_o), 0);
    tick(1);
    chk("R3 miss at k+D+1", 32'(miss_o), 32'h1);
    tick(3);
    chk("R3 miss held", 32'(miss_o), 32'h1);
    req_i[0] = 1'b0;
    tick(3);
    chk("R3 miss held after drop", 32'(miss_o), 32'h1);
    start(0, 100);
    tick(1);
    chk("R2 new request clears miss", 32'(miss_o), 0);
    done_i[0] = 1'b1; tick(1); done_i[0] = 1'b0;
    arb(4'b0000, "R4 completed not granted");
    tick(150);
    chk("R4 no miss after done", 32'(miss_o), 0);
    idle();

    // Reset in the middle of activity (R1)
    start(1, 5);
    tick(10);
    chk("R3 second master miss", 32'(miss_o), 32'h2);
    rst = 1'b1;
    tick(2);
    chk("R1 miss cleared by reset", 32'(miss_o), 0);
    chk("R1 grant cleared by reset", 32'(urg_grant_o), 0);
    rst = 1'b0;
    idle();

    tick(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule